// File: doc/BRIEF.md
# Write-back cache with load-through refill

A 2-way set-associative data cache sits between a processor port and a word-serial memory port. The processor holds a request (read or write, word address, write data) until the cache pulses `ack_o`. Hits complete in the same cycle. A read miss, or a write miss, picks a victim way in the indexed set using a one-bit least-recently-used marker. If that victim is valid and modified, its eight words are sent to memory first. The cache then issues one block read. Memory answers after its own initial latency with eight words, one per cycle, in ascending word order.

The requesting access completes in the cycle its own word arrives (load-through). The rest of the block keeps filling behind it. Any further processor request waits until the block is complete. Writes change only the cache and mark the block modified. Memory sees modified data only when the block is replaced.

Top module: `wlc_cache`

## Requirements
- R1: After reset `ack_o`, `mem_rd_o` and `mem_wr_o` are low and every line is invalid, so the first access to any address causes a block read.
- R2: A read that hits is acknowledged in the same cycle it is presented, returns the stored word on `rdata_o`, and causes no memory traffic.
- R3: `addr_i` is a word address: the low 3 bits select the word in the block, the next 3 bits select the set, and the rest are the tag. A miss issues exactly one single-cycle `mem_rd_o` pulse, whose `mem_addr_o` is the block's first word (offset bits zero).
- R4: Refill words arrive on `mem_rvalid_i` in order 0 to 7. The missing access is acknowledged in the cycle its own word arrives, and a read returns that word on `rdata_o` in the same cycle.
- R5: After a load-through acknowledge, a new processor request is not acknowledged before the cycle after the block's eighth word. It then hits without another block read.
- R6: A write that hits completes in the same cycle, updates only the cache, and produces no `mem_wr_o`. Later reads return the written value.
- R7: A write miss allocates the block through a normal refill, merges the write data at its word, and leaves the block marked modified.
- R8: Each set keeps a least-recently-used marker. A miss replaces the way not accessed most recently, and the other way's block keeps hitting.
- R9: Replacing a modified block first drives eight consecutive `mem_wr_o` cycles carrying words 0 to 7 of the victim at the victim's own address. All of them come before the refill `mem_rd_o`.
- R10: Replacing a clean or invalid line produces no `mem_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Processor word address |
| wdata_i | input | DATA_W | Processor write data |
| ack_o | output | 1 | Access complete this cycle |
| rdata_o | output | DATA_W | Read data, valid with `ack_o` on reads |
| mem_rd_o | output | 1 | Block read request, one cycle |
| mem_wr_o | output | 1 | Write-back word valid this cycle |
| mem_addr_o | output | ADDR_W | Memory word address (block base on reads) |
| mem_wdata_o | output | DATA_W | Write-back word |
| mem_rvalid_i | input | 1 | Refill word valid |
| mem_rdata_i | input | DATA_W | Refill word |

## Verification
Two kinds of internal error matter most: a stale marker bit and a lost modified flag. A wrong marker evicts the block that was just used, which shows as an extra block read on the next access to it. A lost modified flag shows only much later, when the evicted block is read back from memory with old data. The bench therefore replays chosen eviction orders and checks the memory image after each write-back. A wrong refill counter shows at once, as an acknowledge on the wrong beat or a stall that ends before the eighth word.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  localparam int WLC_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_RDREQ,
    ST_FILL
  } wlc_state_e;
endpackage

// File: rtl/wlc_data_ram.sv
module wlc_data_ram
  import wlc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                               clk_i,
  input  logic [IDX_W-1:0]                   ridx_i,
  input  logic [OFF_W-1:0]                   roff_i,
  output logic [WLC_WAYS-1:0][DATA_W-1:0]    rdata_o,
  input  logic                               we_i,
  input  logic                               way_i,
  input  logic [IDX_W-1:0]                   widx_i,
  input  logic [OFF_W-1:0]                   woff_i,
  input  logic [DATA_W-1:0]                  wdata_i
);
  localparam int DEPTH = SETS * WORDS;

  for (genvar w = 0; w < WLC_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && (way_i == w[0])) mem_q[{widx_i, woff_i}] <= wdata_i;
    end

    assign rdata_o[w] = mem_q[{ridx_i, roff_i}];
  end
endmodule

// File: rtl/wlc_tag_dir.sv
module wlc_tag_dir
  import wlc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [IDX_W-1:0]                 idx_i,
  output logic [WLC_WAYS-1:0][TAG_W-1:0]   tag_o,
  output logic [WLC_WAYS-1:0]              valid_o,
  output logic [WLC_WAYS-1:0]              dirty_o,
  output logic                             lru_o,
  input  logic                             fill_i,
  input  logic                             fill_way_i,
  input  logic [TAG_W-1:0]                 fill_tag_i,
  input  logic                             fill_dirty_i,
  input  logic                             dset_i,
  input  logic                             dset_way_i,
  input  logic                             touch_i,
  input  logic                             touch_way_i
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < WLC_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  val_q, dty_q;
    logic             fill_me, dset_me;

    assign fill_me = fill_i && (fill_way_i == w[0]);
    assign dset_me = dset_i && (dset_way_i == w[0]);

    always_ff @(posedge clk_i) begin
      if (fill_me) tag_q[idx_i] <= fill_tag_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        dty_q <= '0;
      end else if (fill_me) begin
        val_q[idx_i] <= 1'b1;
        dty_q[idx_i] <= fill_dirty_i;
      end else if (dset_me) begin
        dty_q[idx_i] <= 1'b1;
      end
    end

    assign tag_o[w]   = tag_q[idx_i];
    assign valid_o[w] = val_q[idx_i];
    assign dirty_o[w] = dty_q[idx_i];
  end

  // marker names the way to evict next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q[idx_i] <= ~touch_way_i;
  end

  assign lru_o = lru_q[idx_i];
endmodule

// File: rtl/wlc_ctrl.sv
module wlc_ctrl
  import wlc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic                             ack_o,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             mem_rd_o,
  output logic                             mem_wr_o,
  output logic [ADDR_W-1:0]                mem_addr_o,
  output logic [DATA_W-1:0]                mem_wdata_o,
  input  logic                             mem_rvalid_i,
  input  logic [DATA_W-1:0]                mem_rdata_i,
  output logic [IDX_W-1:0]                 dir_idx_o,
  input  logic [WLC_WAYS-1:0][TAG_W-1:0]   dir_tag_i,
  input  logic [WLC_WAYS-1:0]              dir_valid_i,
  input  logic [WLC_WAYS-1:0]              dir_dirty_i,
  input  logic                             dir_lru_i,
  output logic                             dir_fill_o,
  output logic                             dir_fill_way_o,
  output logic [TAG_W-1:0]                 dir_fill_tag_o,
  output logic                             dir_fill_dirty_o,
  output logic                             dir_dset_o,
  output logic                             dir_dset_way_o,
  output logic                             dir_touch_o,
  output logic                             dir_touch_way_o,
  output logic [IDX_W-1:0]                 ram_ridx_o,
  output logic [OFF_W-1:0]                 ram_roff_o,
  input  logic [WLC_WAYS-1:0][DATA_W-1:0]  ram_rdata_i,
  output logic                             ram_we_o,
  output logic                             ram_way_o,
  output logic [IDX_W-1:0]                 ram_widx_o,
  output logic [OFF_W-1:0]                 ram_woff_o,
  output logic [DATA_W-1:0]                ram_wdata_o
);
  wlc_state_e state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0]  ltag_q, vtag_q;
  logic [IDX_W-1:0]  lidx_q;
  logic [OFF_W-1:0]  loff_q;
  logic              lwe_q, lway_q;
  logic [DATA_W-1:0] lwdata_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFF_W-1:0]  a_off;
  logic [WLC_WAYS-1:0] hit_vec;
  logic idle, lookup, hit, miss, hway, last, beat, beat_req, vict, vict_dirty;

  assign a_tag = addr_i[ADDR_W-1 -: TAG_W];
  assign a_idx = addr_i[OFF_W +: IDX_W];
  assign a_off = addr_i[OFF_W-1:0];

  for (genvar w = 0; w < WLC_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = dir_valid_i[w] && (dir_tag_i[w] == a_tag);
  end

  assign idle       = (state_q == ST_IDLE);
  assign lookup     = idle && req_i;
  assign hit        = lookup && (|hit_vec);
  assign miss       = lookup && !(|hit_vec);
  assign hway       = hit_vec[1];
  assign last       = (cnt_q == {OFF_W{1'b1}});
  assign beat       = (state_q == ST_FILL) && mem_rvalid_i;
  assign beat_req   = beat && (cnt_q == loff_q);
  assign vict       = dir_lru_i;
  assign vict_dirty = dir_valid_i[vict] && dir_dirty_i[vict];

  // processor side
  assign ack_o   = hit || beat_req;
  assign rdata_o = idle ? ram_rdata_i[hway] : mem_rdata_i;

  // directory and data array addressing
  assign dir_idx_o  = idle ? a_idx : lidx_q;
  assign ram_ridx_o = idle ? a_idx : lidx_q;
  assign ram_roff_o = idle ? a_off : cnt_q;

  assign ram_we_o    = (hit && we_i) || beat;
  assign ram_way_o   = idle ? hway : lway_q;
  assign ram_widx_o  = idle ? a_idx : lidx_q;
  assign ram_woff_o  = idle ? a_off : cnt_q;
  assign ram_wdata_o = idle ? wdata_i :
                       ((lwe_q && (cnt_q == loff_q)) ? lwdata_q : mem_rdata_i);

  assign dir_dset_o       = hit && we_i;
  assign dir_dset_way_o   = hway;
  assign dir_fill_o       = beat && last;
  assign dir_fill_way_o   = lway_q;
  assign dir_fill_tag_o   = ltag_q;
  assign dir_fill_dirty_o = lwe_q;
  assign dir_touch_o      = hit || (beat && last);
  assign dir_touch_way_o  = idle ? hway : lway_q;

  // memory side
  assign mem_rd_o    = (state_q == ST_RDREQ);
  assign mem_wr_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {vtag_q, lidx_q, cnt_q}
                                          : {ltag_q, lidx_q, {OFF_W{1'b0}}};
  assign mem_wdata_o = ram_rdata_i[lway_q];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (miss) state_d = vict_dirty ? ST_WB : ST_RDREQ;
      end
      ST_WB: begin
        cnt_d = cnt_q + 1'b1;
        if (last) state_d = ST_RDREQ;
      end
      ST_RDREQ: begin
        cnt_d   = '0;
        state_d = ST_FILL;
      end
      ST_FILL: begin
        if (mem_rvalid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (last) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ltag_q   <= '0;
      vtag_q   <= '0;
      lidx_q   <= '0;
      loff_q   <= '0;
      lwe_q    <= 1'b0;
      lway_q   <= 1'b0;
      lwdata_q <= '0;
    end else if (miss) begin
      ltag_q   <= a_tag;
      vtag_q   <= dir_tag_i[vict];
      lidx_q   <= a_idx;
      loff_q   <= a_off;
      lwe_q    <= we_i;
      lway_q   <= vict;
      lwdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/wlc_cache.sv
module wlc_cache
  import wlc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]                dir_idx;
  logic [WLC_WAYS-1:0][TAG_W-1:0]  dir_tag;
  logic [WLC_WAYS-1:0]             dir_valid, dir_dirty;
  logic                            dir_lru;
  logic                            dir_fill, dir_fill_way, dir_fill_dirty;
  logic [TAG_W-1:0]                dir_fill_tag;
  logic                            dir_dset, dir_dset_way, dir_touch, dir_touch_way;
  logic [IDX_W-1:0]                ram_ridx, ram_widx;
  logic [OFF_W-1:0]                ram_roff, ram_woff;
  logic [WLC_WAYS-1:0][DATA_W-1:0] ram_rdata;
  logic                            ram_we, ram_way;
  logic [DATA_W-1:0]               ram_wdata;

  wlc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ack_o, .rdata_o,
    .mem_rd_o, .mem_wr_o, .mem_addr_o, .mem_wdata_o, .mem_rvalid_i, .mem_rdata_i,
    .dir_idx_o        (dir_idx),
    .dir_tag_i        (dir_tag),
    .dir_valid_i      (dir_valid),
    .dir_dirty_i      (dir_dirty),
    .dir_lru_i        (dir_lru),
    .dir_fill_o       (dir_fill),
    .dir_fill_way_o   (dir_fill_way),
    .dir_fill_tag_o   (dir_fill_tag),
    .dir_fill_dirty_o (dir_fill_dirty),
    .dir_dset_o       (dir_dset),
    .dir_dset_way_o   (dir_dset_way),
    .dir_touch_o      (dir_touch),
    .dir_touch_way_o  (dir_touch_way),
    .ram_ridx_o       (ram_ridx),
    .ram_roff_o       (ram_roff),
    .ram_rdata_i      (ram_rdata),
    .ram_we_o         (ram_we),
    .ram_way_o        (ram_way),
    .ram_widx_o       (ram_widx),
    .ram_woff_o       (ram_woff),
    .ram_wdata_o      (ram_wdata)
  );

  wlc_tag_dir #(.SETS(SETS), .TAG_W(TAG_W)) u_dir (
    .clk_i, .rst_ni,
    .idx_i        (dir_idx),
    .tag_o        (dir_tag),
    .valid_o      (dir_valid),
    .dirty_o      (dir_dirty),
    .lru_o        (dir_lru),
    .fill_i       (dir_fill),
    .fill_way_i   (dir_fill_way),
    .fill_tag_i   (dir_fill_tag),
    .fill_dirty_i (dir_fill_dirty),
    .dset_i       (dir_dset),
    .dset_way_i   (dir_dset_way),
    .touch_i      (dir_touch),
    .touch_way_i  (dir_touch_way)
  );

  wlc_data_ram #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk_i,
    .ridx_i  (ram_ridx),
    .roff_i  (ram_roff),
    .rdata_o (ram_rdata),
    .we_i    (ram_we),
    .way_i   (ram_way),
    .widx_i  (ram_widx),
    .woff_i  (ram_woff),
    .wdata_i (ram_wdata)
  );
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic [DATA_W-1:0] mem_rdata_i
);
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_i); // R2
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R3
  AST_RD_BLOCK_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o[OFF_W-1:0] == '0)); // R3
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R9
  AST_WB_STARTS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> (mem_addr_o[OFF_W-1:0] == '0)); // R9
  AST_WB_SEQUENTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && $past(mem_wr_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R9
  AST_WB_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_wr_o) |-> mem_rd_o); // R9
  AST_NO_ACK_IN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !ack_o); // R9
endmodule

bind wlc_cache wlc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (.*);

// File: tb/sim_wlc_cache.sv
`timescale 1ns/1ps
module sim_wlc_cache;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rst_ni;
  logic req_i, we_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic ack_o;
  logic [DW-1:0] rdata_o;
  logic mem_rd_o, mem_wr_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic mem_rvalid_i;
  logic [DW-1:0] mem_rdata_i;

  always #2 clk = ~clk;

  wlc_cache #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ack_o, .rdata_o,
    .mem_rd_o, .mem_wr_o, .mem_addr_o, .mem_wdata_o, .mem_rvalid_i, .mem_rdata_i
  );

  int total = 0, bad = 0;
  int cyc = 0;
  logic [DW-1:0] mem_m [2**AW];
  logic [DW-1:0] ref_m [2**AW];
  logic [DW-1:0] exp_q [$];

  // memory model state
  int rd_cnt = 0, wr_cnt = 0;
  int rd_cyc = 0, last_wr_cyc = 0, last_beat_cyc = 0, last_ack_cyc = 0;
  int cur_beat = 0, lat_cnt = 0, beat_n = 0;
  bit beat_on = 0, prev_wr = 0;
  logic [AW-1:0] rd_base = '0, wr_first = '0;

  function automatic logic [DW-1:0] iv(logic [AW-1:0] a);
    return {a, 4'h0, ~a, 4'h5};
  endfunction

  function automatic logic [AW-1:0] mk(int t, int i, int o);
    logic [5:0] tt = t[5:0];
    logic [2:0] ii = i[2:0];
    logic [2:0] oo = o[2:0];
    return {tt, ii, oo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) begin
      mem_m[i] = iv(i[AW-1:0]);
      ref_m[i] = iv(i[AW-1:0]);
    end
  end

  // word-serial memory with initial latency, plus watchdog
  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "R5 watchdog", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      if (beat_on) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_m[rd_base + AW'(beat_n)];
        cur_beat     = beat_n;
        if (beat_n == 7) begin
          beat_on = 0;
          last_beat_cyc = cyc;
        end
        beat_n++;
      end else begin
        mem_rvalid_i = 1'b0;
      end
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          beat_on = 1;
          beat_n  = 0;
        end
      end
      #1;
      if (rst_ni && mem_wr_o) begin
        mem_m[mem_addr_o] = mem_wdata_o;
        wr_cnt++;
        last_wr_cyc = cyc;
        if (!prev_wr) wr_first = mem_addr_o;
      end
      prev_wr = rst_ni && mem_wr_o;
      if (rst_ni && mem_rd_o) begin
        rd_cnt++;
        rd_cyc  = cyc;
        rd_base = mem_addr_o;
        lat_cnt = LAT;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && req_i && ack_o && !we_i) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected read ack", rdata_o, '0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata_o === e, "R2 R4 read data", rdata_o, e);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waits, output int beat_at);
    if (!we) exp_q.push_back(ref_m[a]);
    else     ref_m[a] = d;
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    waits = 0; beat_at = -1;
    while (1) begin
      #1;
      if (ack_o) begin
        if (mem_rvalid_i) beat_at = cur_beat;
        last_ack_cyc = cyc;
        break;
      end
      waits++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w, b, r0, w0;
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(ack_o == 1'b0, "R1 ack low in reset", ack_o, 0);
    chk(mem_rd_o == 1'b0 && mem_wr_o == 1'b0, "R1 memory idle in reset", {mem_rd_o, mem_wr_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    // cold miss, load-through at word 3
    r0 = rd_cnt;
    access(0, mk(1, 2, 3), '0, w, b);
    chk(rd_cnt == r0 + 1, "R1 cold miss fetches", rd_cnt, r0 + 1);
    chk(rd_base == mk(1, 2, 0), "R3 aligned block address", rd_base, mk(1, 2, 0));
    chk(b == 3, "R4 ack on requested beat", b, 3);

    // back-to-back request stalls until the fill completes
    access(0, mk(1, 2, 6), '0, w, b);
    chk(last_ack_cyc > last_beat_cyc, "R5 stall until block complete", last_ack_cyc, last_beat_cyc + 1);
    chk(rd_cnt == r0 + 1, "R5 no refetch after fill", rd_cnt, r0 + 1);

    // read hit
    r0 = rd_cnt; w0 = wr_cnt;
    access(0, mk(1, 2, 0), '0, w, b);
    chk(w == 0, "R2 hit same cycle", w, 0);
    chk(rd_cnt == r0 && wr_cnt == w0, "R2 no memory traffic", rd_cnt + wr_cnt, r0 + w0);

    // write hit
    access(1, mk(1, 2, 5), 32'hdead_beef, w, b);
    chk(w == 0, "R6 write hit same cycle", w, 0);
    chk(wr_cnt == w0, "R6 no write-through", wr_cnt, w0);
    chk(mem_m[mk(1, 2, 5)] == iv(mk(1, 2, 5)), "R6 backing store unchanged", mem_m[mk(1, 2, 5)], iv(mk(1, 2, 5)));
    access(0, mk(1, 2, 5), '0, w, b);

    // second way, invalid victim, load-through at last word
    access(0, mk(2, 2, 7), '0, w, b);
    chk(wr_cnt == w0, "R10 invalid victim no write-back", wr_cnt, w0);
    chk(b == 7, "R4 ack on last beat", b, 7);

    // touch tag 1 so tag 2 becomes the victim
    r0 = rd_cnt;
    access(0, mk(1, 2, 1), '0, w, b);
    chk(rd_cnt == r0, "R8 older block still resident", rd_cnt, r0);

    access(0, mk(3, 2, 2), '0, w, b);
    chk(wr_cnt == w0, "R10 clean victim no write-back", wr_cnt, w0);

    // tag 1 (dirty) is now least recent
    access(0, mk(5, 2, 4), '0, w, b);
    chk(wr_cnt == w0 + 8, "R9 eight write-back words", wr_cnt, w0 + 8);
    chk(wr_first == mk(1, 2, 0), "R9 write-back at victim address", wr_first, mk(1, 2, 0));
    chk(last_wr_cyc < rd_cyc, "R9 write-back before refill", last_wr_cyc, rd_cyc - 1);
    chk(mem_m[mk(1, 2, 5)] == 32'hdead_beef, "R9 modified word reaches memory", mem_m[mk(1, 2, 5)], 32'hdead_beef);

    r0 = rd_cnt;
    access(0, mk(3, 2, 2), '0, w, b);
    chk(rd_cnt == r0, "R8 most recent block kept", rd_cnt, r0);

    // write miss allocates and merges
    r0 = rd_cnt; w0 = wr_cnt;
    access(1, mk(6, 5, 3), 32'h1234_5678, w, b);
    chk(rd_cnt == r0 + 1, "R7 write miss allocates", rd_cnt, r0 + 1);
    chk(b == 3, "R7 write completes on its beat", b, 3);
    access(0, mk(6, 5, 3), '0, w, b);
    access(0, mk(6, 5, 4), '0, w, b);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R7 merged block hits", rd_cnt, r0 + 1);

    // load-through on word 0
    access(0, mk(7, 1, 0), '0, w, b);
    chk(b == 0, "R4 ack on first beat", b, 0);

    // evict the block dirtied by the write miss
    access(0, mk(8, 5, 0), '0, w, b);
    access(0, mk(9, 5, 0), '0, w, b);
    chk(mem_m[mk(6, 5, 3)] == 32'h1234_5678, "R7 R9 allocated write written back", mem_m[mk(6, 5, 3)], 32'h1234_5678);

    // mixed traffic over two sets and four tags
    for (int k = 0; k < 400; k++) begin
      bit wr = ($urandom % 3) == 0;
      access(wr, mk($urandom % 4, $urandom % 2, $urandom % 8), $urandom, w, b);
    end
    idle(2);
    chk(exp_q.size() == 0, "R2 every read answered", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule